// File: doc/BRIEF.md
# UART Transmit Channel with Flow Control and Looping Modes

This block is the transmit half of a serial channel. A byte arrives on a valid/ready write port and goes into a one-entry holding register. A shift register then sends it as an asynchronous frame, one bit every sixteen baud ticks. When clear-to-send gating is on, each character waits for CTS before it starts. When automatic request-to-send is on, RTS drops one bit time after the last character has fully left the line.

A channel-mode field routes the serial lines in one of four ways:
- Normal operation.
- Automatic echo of the received line.
- Local loopback, with the transmit output turned back into the receive path.
- Remote loopback.

Two mode registers sit behind one register-bus address and are reached through a pointer that moves forward on its own. A second address takes commands on a write and returns status on a read.

The write port follows valid/ready rules:
- A byte is taken on a cycle where `tx_valid` and `tx_ready` are both high.
- `tx_ready` is high only while the holding register is empty.
- A sender holding `tx_valid` high while `tx_ready` is low must keep `tx_data` stable until the transfer happens.
- A byte that has been accepted waits in the holding register until it can start.

Top module: `uart_tx_fc`

## Requirements
- R1: After reset, mode accesses (`reg_sel`=0) reach mode register A. Any read or write of A moves the pointer to mode register B. Accesses to B leave the pointer on B. A command write (`reg_sel`=1) with bit 0 set moves the pointer back to A.
- R2: Both mode registers reset to 0x00 and read back the last value written to them.
- R3: A frame consists of the following bits, each lasting 16 baud ticks:
  - one low start bit;
  - 8 data bits, LSB first;
  - high stop bits: one when bits 3..0 of mode register B are zero, two when they are non-zero.
- R4: `tx_ready` is high exactly while the holding register is empty. Once a character starts, the next byte is accepted while that character is still shifting out, and the two characters are sent back to back.
- R5: While `tx_en` is low, no character starts and `txd` stays high. A byte that is already held starts after `tx_en` rises.
- R6: When bit 4 of mode register B is set and `cts` is low, a held character does not start and `txd` stays high. The character starts once `cts` goes high.
- R7: A change on `cts` while a character is shifting out leaves that character unchanged.
- R8: A command write with bit 1 set raises `rts`, and one with bit 2 set lowers it. When bit 5 of mode register B is set, `rts` falls one bit time (16 ticks) after the last stop bit, provided the holding register is empty.
- R9: When bit 7 of mode register A (receiver RTS control) and bit 5 of mode register B are both set, `rts` is never lowered automatically.
- R10: Bits 7..6 of mode register B select how `txd` and `rx_line` are driven:

  | Bits 7..6 | Mode | `txd` | `rx_line` |
  |---|---|---|---|
  | 00 | normal | transmitter | `rxd` |
  | 01 | echo | `rxd` | `rxd` |
  | 10 | local loopback | held high | transmitter |
  | 11 | remote loopback | `rxd` | held high |
- R11: A status read (`reg_sel`=1) returns bit 0 = holding register empty and bit 1 = holding and shift registers both empty. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 = mode register (through the pointer), 1 = command/status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Holding register can take a byte |
| tx_data | input | 8 | Transmit byte |
| baud_tick | input | 1 | One pulse per 1/16 bit time |
| tx_en | input | 1 | Transmitter enable |
| rxd | input | 1 | Serial receive pin |
| cts | input | 1 | Clear-to-send, high = asserted |
| txd | output | 1 | Serial transmit pin |
| rts | output | 1 | Request-to-send, high = asserted |
| rx_line | output | 1 | Serial line handed to the receiver |

## Verification
The hardest case to reach from the ports is the delayed RTS drop. It needs automatic RTS enabled, RTS raised by command, and a frame sent with nothing left waiting behind it. The line must then be watched across the extra bit time, with `rts` sampled both just before and just after its edge, measured from the start bit seen on `txd`.

The conflict case reuses the same sequence with receiver RTS control also set. CTS blocking and mid-character CTS changes are reached by holding a byte in the holding register before raising `cts`, and by dropping `cts` partway through a frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    CH_NORMAL = 2'b00,
    CH_ECHO   = 2'b01,
    CH_LOCAL  = 2'b10,
    CH_REMOTE = 2'b11
  } chan_mode_e;

  typedef struct packed {
    chan_mode_e  mode;
    logic        auto_rts;
    logic        cts_gate;
    logic [3:0]  stop_sel;
  } mode_b_t;

  typedef enum logic [1:0] {
    TX_IDLE    = 2'b00,
    TX_SHIFT   = 2'b01,
    TX_RTSWAIT = 2'b10
  } tx_state_e;

  localparam int unsigned CMD_PTR_RST = 0;
  localparam int unsigned CMD_RTS_SET = 1;
  localparam int unsigned CMD_RTS_CLR = 2;
  localparam int unsigned RX_RTS_BIT  = 7;
endpackage

// File: rtl/uart_mode_regs.sv
module uart_mode_regs #(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] mode_rdata,
  output logic [REG_W-1:0] mode_b,
  output logic             rx_rts_own,
  output logic             mode_ptr
);
  import uart_tx_pkg::*;

  localparam int unsigned NREG = 2;

  logic [REG_W-1:0] mr_q [NREG];
  logic             mode_acc;
  logic             ptr_rst;

  assign mode_acc = !reg_sel && (reg_wr || reg_rd);
  assign ptr_rst  = reg_sel && reg_wr && reg_wdata[CMD_PTR_RST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_ptr <= 1'b0;
    end else if (ptr_rst) begin
      mode_ptr <= 1'b0;
    end else if (mode_acc && !mode_ptr) begin
      mode_ptr <= 1'b1;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_mr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mr_q[i] <= '0;
      end else if (!reg_sel && reg_wr && (mode_ptr == i[0])) begin
        mr_q[i] <= reg_wdata;
      end
    end
  end

  assign mode_rdata = mode_ptr ? mr_q[1] : mr_q[0];
  assign mode_b     = mr_q[1];
  assign rx_rts_own = mr_q[0][RX_RTS_BIT];
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              cts,
  input  logic              cts_gate,
  input  logic              auto_rts,
  input  logic              rts_now,
  input  logic              two_stop,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              ser_out,
  output logic              hold_empty,
  output logic              all_empty,
  output logic              busy,
  output logic              rts_drop
);
  import uart_tx_pkg::*;

  localparam int unsigned TCW       = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int unsigned FRAME_MAX = DATA_W + 3;
  localparam int unsigned BCW       = $clog2(FRAME_MAX + 1);
  localparam logic [TCW-1:0] TICK_LAST = TCW'(TICKS_PER_BIT - 1);

  tx_state_e            state_q;
  logic [DATA_W-1:0]    hold_q;
  logic                 hold_full;
  logic [FRAME_MAX-1:0] shreg_q;
  logic [BCW-1:0]       bits_left;
  logic [TCW-1:0]       tick_q;
  logic                 can_start;
  logic                 bit_done;

  assign in_ready  = !hold_full;
  assign can_start = (state_q != TX_SHIFT) && hold_full && tx_en && (!cts_gate || cts);
  assign bit_done  = baud_tick && (tick_q == TICK_LAST);
  assign rts_drop  = (state_q == TX_RTSWAIT) && bit_done && !hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else if (in_valid && in_ready) begin
      hold_full <= 1'b1;
      hold_q    <= in_data;
    end else if (can_start) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= TX_IDLE;
      shreg_q   <= '1;
      bits_left <= '0;
      tick_q    <= '0;
    end else begin
      case (state_q)
        TX_SHIFT: begin
          if (baud_tick) begin
            tick_q <= bit_done ? '0 : tick_q + 1'b1;
          end
          if (bit_done) begin
            shreg_q   <= {1'b1, shreg_q[FRAME_MAX-1:1]};
            bits_left <= bits_left - 1'b1;
            if (bits_left == BCW'(1)) begin
              state_q <= (auto_rts && rts_now && !hold_full) ? TX_RTSWAIT : TX_IDLE;
            end
          end
        end
        default: begin
          if (can_start) begin
            shreg_q   <= {2'b11, hold_q, 1'b0};
            bits_left <= two_stop ? BCW'(FRAME_MAX) : BCW'(FRAME_MAX - 1);
            tick_q    <= '0;
            state_q   <= TX_SHIFT;
          end else if (state_q == TX_RTSWAIT) begin
            if (hold_full) begin
              state_q <= TX_IDLE;
            end else if (baud_tick) begin
              tick_q <= bit_done ? '0 : tick_q + 1'b1;
              if (bit_done) state_q <= TX_IDLE;
            end
          end
        end
      endcase
    end
  end

  assign busy       = (state_q == TX_SHIFT);
  assign ser_out    = busy ? shreg_q[0] : 1'b1;
  assign hold_empty = !hold_full;
  assign all_empty  = !hold_full && !busy;
endmodule

// File: rtl/uart_chan_mux.sv
module uart_chan_mux (
  input  uart_tx_pkg::chan_mode_e mode,
  input  logic                    ser_out,
  input  logic                    rxd,
  output logic                    txd,
  output logic                    rx_line
);
  import uart_tx_pkg::*;

  always_comb begin
    case (mode)
      CH_ECHO: begin
        txd     = rxd;
        rx_line = rxd;
      end
      CH_LOCAL: begin
        txd     = 1'b1;
        rx_line = ser_out;
      end
      CH_REMOTE: begin
        txd     = rxd;
        rx_line = 1'b1;
      end
      default: begin
        txd     = ser_out;
        rx_line = rxd;
      end
    endcase
  end
endmodule

// File: rtl/uart_tx_fc.sv
module uart_tx_fc #(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              rxd,
  input  logic              cts,
  output logic              txd,
  output logic              rts,
  output logic              rx_line
);
  import uart_tx_pkg::*;

  localparam int unsigned REG_W = 8;

  logic [REG_W-1:0] mode_rdata;
  logic [REG_W-1:0] mode_b_raw;
  mode_b_t          mode_b;
  logic             rx_rts_own;
  logic             mode_ptr;
  logic             auto_rts_en;
  logic             ser_out;
  logic             hold_empty;
  logic             all_empty;
  logic             core_busy;
  logic             rts_drop;
  logic             cmd_wr;
  logic             rts_q;

  uart_mode_regs #(.REG_W(REG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .mode_rdata (mode_rdata),
    .mode_b     (mode_b_raw),
    .rx_rts_own (rx_rts_own),
    .mode_ptr   (mode_ptr)
  );

  assign mode_b      = mode_b_t'(mode_b_raw);
  assign auto_rts_en = mode_b.auto_rts && !rx_rts_own;

  uart_tx_core #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .tx_en      (tx_en),
    .cts        (cts),
    .cts_gate   (mode_b.cts_gate),
    .auto_rts   (auto_rts_en),
    .rts_now    (rts_q),
    .two_stop   (|mode_b.stop_sel),
    .in_valid   (tx_valid),
    .in_data    (tx_data),
    .in_ready   (tx_ready),
    .ser_out    (ser_out),
    .hold_empty (hold_empty),
    .all_empty  (all_empty),
    .busy       (core_busy),
    .rts_drop   (rts_drop)
  );

  uart_chan_mux u_mux (
    .mode    (mode_b.mode),
    .ser_out (ser_out),
    .rxd     (rxd),
    .txd     (txd),
    .rx_line (rx_line)
  );

  assign cmd_wr = reg_sel && reg_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rts_q <= 1'b0;
    end else if (cmd_wr && reg_wdata[CMD_RTS_SET]) begin
      rts_q <= 1'b1;
    end else if (cmd_wr && reg_wdata[CMD_RTS_CLR]) begin
      rts_q <= 1'b0;
    end else if (rts_drop) begin
      rts_q <= 1'b0;
    end
  end

  assign rts       = rts_q;
  assign reg_rdata = reg_sel ? {6'b0, all_empty, hold_empty} : mode_rdata;
endmodule

// File: rtl/uart_tx_fc_chk.sv
module uart_tx_fc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_sel,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_wdata,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_en,
  input logic       cts,
  input logic       rxd,
  input logic       txd,
  input logic       rts,
  input logic       mode_ptr,
  input logic [7:0] mode_b_raw,
  input logic       rx_rts_own,
  input logic       core_busy
);
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_sel && (reg_wr || reg_rd) && !mode_ptr) |=> mode_ptr); // R1
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ptr && !(reg_sel && reg_wr && reg_wdata[0])) |=> mode_ptr); // R1
  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready); // R4
  AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !core_busy) |=> !core_busy); // R5
  AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b_raw[4] && !cts && !core_busy) |=> !core_busy); // R6
  AST_RTS_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    (rts && rx_rts_own && !(reg_sel && reg_wr && reg_wdata[2])) |=> rts); // R9
  AST_LOCAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b_raw[7:6] == 2'b10) |-> txd); // R10
  AST_REMOTE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b_raw[7:6] == 2'b11) |-> (txd == rxd)); // R10
endmodule

bind uart_tx_fc uart_tx_fc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_sel    (reg_sel),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_wdata  (reg_wdata),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_en      (tx_en),
  .cts        (cts),
  .rxd        (rxd),
  .txd        (txd),
  .rts        (rts),
  .mode_ptr   (mode_ptr),
  .mode_b_raw (mode_b_raw),
  .rx_rts_own (rx_rts_own),
  .core_busy  (core_busy)
);

// File: tb/uart_tx_fc_tb.sv
`timescale 1ns/1ps
module uart_tx_fc_tb;
  localparam int BIT_NS = 320;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [7:0] tx_data = '0;
  logic baud_tick = 1'b0;
  logic tx_en = 1'b1, rxd = 1'b1, cts = 1'b1;
  logic txd, rts, rx_line;
  logic mon_sel = 1'b0;
  wire  mon = mon_sel ? rx_line : txd;

  int n_chk = 0;
  int n_fail = 0;
  int txd_low_cnt = 0;

  always #5 clk = ~clk;
  always @(posedge clk) baud_tick <= ~baud_tick;
  always @(negedge clk) if (!txd) txd_low_cnt <= txd_low_cnt + 1;

  uart_tx_fc u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .baud_tick(baud_tick), .tx_en(tx_en), .rxd(rxd), .cts(cts),
    .txd(txd), .rts(rts), .rx_line(rx_line)
  );

  // {stop_field_nonzero, data}
  localparam logic [8:0] VEC [6] = '{
    {1'b0, 8'hA5}, {1'b1, 8'h00}, {1'b0, 8'hFF},
    {1'b1, 8'h3C}, {1'b0, 8'h81}, {1'b1, 8'h5A}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mode_wr(input logic [7:0] d);
    @(negedge clk); reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic mode_rd(output logic [7:0] d);
    @(negedge clk); reg_sel = 1'b0; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d);
    @(negedge clk); reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic stat_rd(output logic [7:0] d);
    @(negedge clk); reg_sel = 1'b1; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic set_modes(input logic [7:0] a, input logic [7:0] b);
    cmd(8'h01); mode_wr(a); mode_wr(b);
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic rx_frame(input bit two, output logic [7:0] d, output bit ok, output time t0);
    @(negedge mon);
    t0 = $time;
    #(BIT_NS/2 + 5);
    ok = (mon == 1'b0);
    for (int i = 0; i < 8; i++) begin
      #(BIT_NS); d[i] = mon;
    end
    #(BIT_NS); ok = ok && mon;
    if (two) begin
      #(BIT_NS); ok = ok && mon;
    end
  endtask

  task automatic xfer(input logic [7:0] v, input bit two, output logic [7:0] d, output bit ok, output time t0);
    fork
      send(v);
      rx_frame(two, d, ok, t0);
    join
  endtask

  task automatic quiet_cycles(input int n, output int lows);
    int start_cnt;
    start_cnt = txd_low_cnt;
    repeat (n) @(negedge clk);
    lows = txd_low_cnt - start_cnt;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    bit ok, ok2;
    time t0, t1, te;
    int lows;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state: R2, R11
    check(txd == 1'b1 && rts == 1'b0, "R2 reset pins", {txd, rts}, 2'b10);
    mode_rd(d); check(d == 8'h00, "R2 reset mode A", d, 8'h00);
    mode_rd(d); check(d == 8'h00, "R2 reset mode B", d, 8'h00);
    stat_rd(d); check(d == 8'h03, "R11 reset status", d, 8'h03);

    // Pointer behaviour: R1, R2
    cmd(8'h01);
    mode_wr(8'h12); mode_wr(8'h07); mode_wr(8'h09);
    cmd(8'h01);
    mode_rd(d); check(d == 8'h12, "R1 pointer back to A", d, 8'h12);
    mode_rd(d); check(d == 8'h09, "R1 B writes stay on B", d, 8'h09);
    mode_rd(d); check(d == 8'h09, "R1 B read keeps pointer", d, 8'h09);
    set_modes(8'h00, 8'h00);

    // Frame table: R3
    for (int k = 0; k < 6; k++) begin
      logic [7:0] v;
      bit two;
      v = VEC[k][7:0];
      two = VEC[k][8];
      set_modes(8'h00, two ? 8'h08 : 8'h00);
      xfer(v, two, d, ok, t0);
      check(d == v, "R3 data bits", d, v);
      check(ok, "R3 start/stop levels", ok, 1);
      @(negedge clk); reg_sel = 1'b1; reg_rd = 1'b1;
      te = 0;
      for (int c = 0; c < 200 && te == 0; c++) begin
        #1 if (reg_rdata[1]) te = $time;
        @(negedge clk);
      end
      reg_rd = 1'b0; reg_sel = 1'b0;
      begin
        int exp_ns, got_ns;
        exp_ns = (two ? 11 : 10) * BIT_NS;
        got_ns = int'(te - t0);
        check(got_ns > exp_ns - 25 && got_ns < exp_ns + 25, "R3 frame length / R11 empty", got_ns, exp_ns);
      end
    end
    set_modes(8'h00, 8'h00);

    // Back-to-back: R4
    fork
      begin send(8'hC6); send(8'h39); end
      begin rx_frame(1'b0, d, ok, t0); rx_frame(1'b0, d2, ok2, t1); end
    join
    check(d == 8'hC6 && ok, "R4 first of pair", d, 8'hC6);
    check(d2 == 8'h39 && ok2, "R4 second of pair", d2, 8'h39);
    check(int'(t1 - t0) < 11 * BIT_NS, "R4 pair back to back", int'(t1 - t0), 10 * BIT_NS);
    #(BIT_NS);

    // Transmit enable: R5, R4, R11
    tx_en = 1'b0;
    send(8'h3E);
    check(tx_ready == 1'b0, "R4 ready low while held", tx_ready, 0);
    stat_rd(d); check(d == 8'h00, "R11 status while held", d, 8'h00);
    quiet_cycles(100, lows);
    check(lows == 0, "R5 no start while disabled", lows, 0);
    fork
      begin @(negedge clk); tx_en = 1'b1; end
      rx_frame(1'b0, d, ok, t0);
    join
    check(d == 8'h3E && ok, "R5 starts after enable", d, 8'h3E);
    #(BIT_NS);

    // CTS gating: R6, R7
    set_modes(8'h00, 8'h10);
    cts = 1'b0;
    send(8'h55);
    quiet_cycles(100, lows);
    check(lows == 0, "R6 held while cts low", lows, 0);
    fork
      begin @(negedge clk); cts = 1'b1; end
      rx_frame(1'b0, d, ok, t0);
    join
    check(d == 8'h55 && ok, "R6 starts after cts", d, 8'h55);
    #(BIT_NS);
    fork
      xfer(8'hC3, 1'b0, d, ok, t0);
      begin #1000; cts = 1'b0; end
    join
    check(d == 8'hC3 && ok, "R7 cts drop mid character", d, 8'hC3);
    cts = 1'b1;
    #(BIT_NS);

    // Automatic RTS: R8
    set_modes(8'h00, 8'h20);
    cmd(8'h02);
    check(rts == 1'b1, "R8 command raises rts", rts, 1);
    xfer(8'h6D, 1'b0, d, ok, t0);
    #(315);
    check(rts == 1'b1, "R8 rts kept during extra bit", rts, 1);
    #(240);
    check(rts == 1'b0, "R8 rts dropped one bit after end", rts, 0);

    // Conflict: R9, R8
    set_modes(8'h80, 8'h20);
    cmd(8'h02);
    xfer(8'h4A, 1'b0, d, ok, t0);
    #(1200);
    check(rts == 1'b1, "R9 conflict keeps rts", rts, 1);
    cmd(8'h04);
    check(rts == 1'b0, "R8 command lowers rts", rts, 0);

    // Channel modes: R10
    set_modes(8'h00, 8'h00);
    @(negedge clk); rxd = 1'b0; #2;
    check(rx_line == 1'b0 && txd == 1'b1, "R10 normal", {rx_line, txd}, 2'b01);
    rxd = 1'b1;
    set_modes(8'h00, 8'h40);
    @(negedge clk); rxd = 1'b0; #2;
    check(txd == 1'b0 && rx_line == 1'b0, "R10 echo", {txd, rx_line}, 2'b00);
    rxd = 1'b1;
    set_modes(8'h00, 8'hC0);
    @(negedge clk); rxd = 1'b0; #2;
    check(txd == 1'b0 && rx_line == 1'b1, "R10 remote", {txd, rx_line}, 2'b01);
    rxd = 1'b1;
    set_modes(8'h00, 8'h80);
    mon_sel = 1'b1;
    lows = txd_low_cnt;
    xfer(8'h96, 1'b0, d, ok, t0);
    check(d == 8'h96 && ok, "R10 local loop data", d, 8'h96);
    check(txd_low_cnt == lows, "R10 local txd high", txd_low_cnt - lows, 0);
    mon_sel = 1'b0;
    #(BIT_NS);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule